// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-load engine of a byte-wide EEPROM array and watches every completed write cycle (address plus data byte). It holds a persistent write-protect flag and recognises two key sequences. The first is a three-write key, which either arms protection or opens one protected burst. The second is a six-write key, which removes protection. For each write it tells the page engine, through a one-cycle permit pulse, whether that byte may go into the page buffer.

Writes are grouped into bursts. A burst stays open while each write follows the previous one within a byte-load window of `WIN_CYC` clock cycles. When the window runs out, the burst closes and a write period of `PROG_CYC` cycles follows. A pending change to the protect flag is applied on the last edge of that write period. Key writes are consumed by the matcher and are never loaded. The protect flag has no reset, so a reset pulse leaves it where it was.

Top module: `wpcmd_guard`

## Requirements
- R1: After power-up `protect` is 0. While `protect` is 0, an ordinary accepted write gives a `load_ok` pulse that is high during the cycle after the clock edge that captured `wr_stb`.
- R2: Asserting `rst_n` low for any number of cycles leaves `protect` unchanged.
- R3: The three-write key is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Only address bits [14:0] are compared and higher bits are ignored. Issued while unprotected, it sets `protect` at the end of the write period, even when no data byte follows. The key writes themselves give no `load_ok`.
- R4: While `protect` is 1, the writes of a burst that does not begin with the three-write key give no `load_ok`.
- R5: While `protect` is 1, data writes that follow the three-write key in the same burst give `load_ok`. The next burst is locked again unless it also carries the key.
- R6: The six-write key is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It clears `protect` at the end of the write period. Data writes that follow it in the same burst give `load_ok`.
- R7: A write that does not match the expected next key step returns the matcher to idle. That write is then handled as an ordinary write under the current protect state, and the abandoned sequence changes nothing.
- R8: A write that arrives at most `WIN_CYC` cycles after the previous accepted write belongs to the same burst. If `WIN_CYC` cycles pass with no write, the burst closes, `busy` rises, and any partial key progress is discarded.
- R9: `busy` stays high for `PROG_CYC` cycles. Writes presented while `busy` is high are ignored: they give no `load_ok` and no key progress. `protect` changes only on the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (the protect flag is not affected) |
| wr_stb | input | 1 | One-cycle strobe marking a completed write cycle |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| load_ok | output | 1 | Pulse: the byte captured one edge earlier may be loaded into the page |
| protect | output | 1 | Persistent write-protect flag |
| busy | output | 1 | Write period in progress; writes are ignored |

## Verification
The hardest situation to reach from the ports is a key sequence that is broken partway through, either by a wrong write at a chosen step or by the byte-load window running out between two steps. The expected outcome depends on both the current protect state and the step reached. The stimulus therefore sweeps the break point over every step of the six-write key while protected, and repeats a mismatch case while unprotected so that the ordinary handling of the breaking write is visible on `load_ok`. It also sweeps the spacing between key writes from one cycle up to the window length, plus one cycle more, with the window set short so that each burst closes within a few cycles.

// File: rtl/wpcmd_pkg.sv
// Shared types and key constants for the write-protect sequence detector.
// Assumes byte-wide data and a 15-bit compared key address.
package wpcmd_pkg;
    localparam int BYTE_W = 8;
    localparam int KEY_AW = 15;

    localparam logic [KEY_AW-1:0] KA_MAIN = 15'h5555;
    localparam logic [KEY_AW-1:0] KA_ALT  = 15'h2AAA;

    localparam logic [BYTE_W-1:0] KD_FIRST  = 8'hAA;
    localparam logic [BYTE_W-1:0] KD_SECOND = 8'h55;
    localparam logic [BYTE_W-1:0] KD_ARM    = 8'hA0;
    localparam logic [BYTE_W-1:0] KD_EXTEND = 8'h80;
    localparam logic [BYTE_W-1:0] KD_DISARM = 8'h20;

    // Matcher progress: S_K1/S_K2 after steps one and two, S_X3..S_X5 in the long key
    typedef enum logic [2:0] {
        S_IDLE, S_K1, S_K2, S_X3, S_X4, S_X5
    } seq_t;

    // Protect change waiting for the end of the write period
    typedef enum logic [1:0] {
        T_KEEP, T_SET, T_CLR
    } tgt_t;
endpackage

// File: rtl/wpcmd_seq.sv
// Key sequence matcher. Advances one step per matching accepted write and
// returns to idle on any mismatch or when the burst closes.
// Assumes stb and clr never coincide (the burst only closes in a write-free cycle).
module wpcmd_seq
    import wpcmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output logic              adv,
    output logic              hit_arm,
    output logic              hit_disarm
);
    seq_t state_q, state_d;
    logic at_main, at_alt;

    assign at_main = (addr[KEY_AW-1:0] == KA_MAIN);
    assign at_alt  = (addr[KEY_AW-1:0] == KA_ALT);

    // Next-step decision for the current write
    always_comb begin
        state_d    = state_q;
        adv        = 1'b0;
        hit_arm    = 1'b0;
        hit_disarm = 1'b0;
        if (stb) begin
            state_d = S_IDLE;
            unique case (state_q)
                S_IDLE: if (at_main && data == KD_FIRST)  begin state_d = S_K1; adv = 1'b1; end
                S_K1:   if (at_alt  && data == KD_SECOND) begin state_d = S_K2; adv = 1'b1; end
                S_K2: begin
                    if (at_main && data == KD_ARM) begin
                        adv = 1'b1; hit_arm = 1'b1;
                    end else if (at_main && data == KD_EXTEND) begin
                        state_d = S_X3; adv = 1'b1;
                    end
                end
                S_X3:   if (at_main && data == KD_FIRST)  begin state_d = S_X4; adv = 1'b1; end
                S_X4:   if (at_alt  && data == KD_SECOND) begin state_d = S_X5; adv = 1'b1; end
                S_X5:   if (at_main && data == KD_DISARM) begin adv = 1'b1; hit_disarm = 1'b1; end
                default: state_d = S_IDLE;
            endcase
        end else if (clr) begin
            state_d = S_IDLE;
        end
    end

    // Progress register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wpcmd_timer.sv
// Burst window and write-period timer sharing one counter.
// Opens a burst on an accepted write, closes it after WIN_CYC quiet cycles,
// then holds busy for PROG_CYC cycles and pulses commit on the last one.
module wpcmd_timer #(
    parameter int WIN_CYC  = 4,
    parameter int PROG_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    output logic open,
    output logic close,
    output logic busy,
    output logic commit
);
    localparam int MAXC  = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             open_q, busy_q;

    assign close  = open_q && !acc && (cnt_q == WIN_LAST);
    assign commit = busy_q && (cnt_q == PROG_LAST);
    assign open   = open_q;
    assign busy   = busy_q;

    // Window / write-period sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0; open_q <= 1'b0; busy_q <= 1'b0;
        end else if (busy_q) begin
            if (commit) begin busy_q <= 1'b0; cnt_q <= '0; end
            else        cnt_q <= cnt_q + 1'b1;
        end else if (acc) begin
            open_q <= 1'b1; cnt_q <= '0;
        end else if (open_q) begin
            if (close) begin open_q <= 1'b0; busy_q <= 1'b1; cnt_q <= '0; end
            else       cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wpcmd_guard.sv
// Write-protect sequence detector top. Combines the key matcher and the
// burst timer, keeps the persistent protect flag and issues load permits.
// Assumes wr_stb is a one-cycle pulse per completed write cycle.
module wpcmd_guard
    import wpcmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int WIN_CYC  = 4,
    parameter int PROG_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              load_ok,
    output logic              protect,
    output logic              busy
);
    logic acc, adv, hit_arm, hit_disarm;
    logic open, close, commit;
    logic unlocked_q, load_q;
    logic prot_q = 1'b0;
    tgt_t tgt_q;

    assign acc = wr_stb && !busy;

    wpcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .stb(acc), .clr(close),
        .addr(wr_addr), .data(wr_data),
        .adv(adv), .hit_arm(hit_arm), .hit_disarm(hit_disarm)
    );

    wpcmd_timer #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .open(open), .close(close), .busy(busy), .commit(commit)
    );

    // Burst unlock and pending protect change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
            tgt_q      <= T_KEEP;
        end else begin
            if (close)                       unlocked_q <= 1'b0;
            else if (hit_arm || hit_disarm)  unlocked_q <= 1'b1;
            if (commit)          tgt_q <= T_KEEP;
            else if (hit_arm)    tgt_q <= T_SET;
            else if (hit_disarm) tgt_q <= T_CLR;
        end
    end

    // Load permit for the byte just captured
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= acc && !adv && (!prot_q || unlocked_q);
    end

    // Persistent protect flag: no reset, updated only at end of write period
    always_ff @(posedge clk) begin
        if (rst_n && commit) begin
            if (tgt_q == T_SET)      prot_q <= 1'b1;
            else if (tgt_q == T_CLR) prot_q <= 1'b0;
        end
    end

    assign load_ok = load_q;
    assign protect = prot_q;
endmodule

// File: rtl/wpcmd_guard_chk.sv
// Timing properties of the write-protect detector, bound to its top.
module wpcmd_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic load_ok,
    input logic protect,
    input logic busy
);
    // R2: reset leaves the flag alone
    p_hold_in_reset_r2: assert property (@(posedge clk)
        !rst_n |=> $stable(protect));

    // R9: the flag moves only as the write period ends
    p_change_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(protect) |-> $fell(busy));

    // R9: nothing is loaded from a write seen during the write period
    p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !load_ok);

    // R1: a permit always answers a write strobe
    p_permit_follows_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |-> $past(wr_stb));

    // R8: a burst only closes in a cycle without a write
    p_close_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wr_stb));
endmodule

bind wpcmd_guard wpcmd_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .load_ok(load_ok), .protect(protect), .busy(busy)
);

// File: tb/wpcmd_guard_test.sv
`timescale 1ns/1ps
module wpcmd_guard_test;
    localparam int AW   = 17;
    localparam int WIN  = 4;
    localparam int PROG = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          load_ok, protect, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wpcmd_guard #(.ADDR_W(AW), .WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_ok(load_ok), .protect(protect), .busy(busy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One write captured on the next rising edge; permit sampled half a cycle later
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic exp_load, input string req);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(req, load_ok, exp_load);
    endtask

    // Called just after the last write: checks window close and commit edges
    task automatic end_burst(input logic old_p, input logic new_p, input string req);
        idle(WIN - 1);
        check({req, " busy low inside window"}, busy, 1'b0);
        idle(1);
        check({req, " busy after window"}, busy, 1'b1);
        idle(PROG - 1);
        check({req, " flag before end"}, protect, old_p);
        idle(1);
        check({req, " busy fall"}, busy, 1'b0);
        check({req, " flag after end"}, protect, new_p);
    endtask

    task automatic key3(input string req);
        wr(17'h05555, 8'hAA, 1'b0, req);
        wr(17'h02AAA, 8'h55, 1'b0, req);
        wr(17'h05555, 8'hA0, 1'b0, req);
    endtask

    function automatic logic [AW-1:0] step_addr(input int s);
        return (s == 1 || s == 4) ? 17'h02AAA : 17'h05555;
    endfunction

    function automatic logic [7:0] step_data(input int s);
        case (s)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: state out of reset
        check("R1 protect at power-up", protect, 1'b0);
        check("R1 load_ok in reset", load_ok, 1'b0);
        rst_n = 1'b1;
        idle(1);
        check("R9 busy idle", busy, 1'b0);

        // R1: ordinary writes while unprotected
        wr(17'h00010, 8'h3C, 1'b1, "R1 plain write");
        wr(17'h00011, 8'hAA, 1'b1, "R1 plain write 2");
        end_burst(1'b0, 1'b0, "R1");

        // R3: arm with high address bits set, no trailing data
        wr(17'h15555, 8'hAA, 1'b0, "R3 step1");
        wr(17'h12AAA, 8'h55, 1'b0, "R3 step2");
        wr(17'h1D555, 8'hA0, 1'b0, "R3 step3");
        end_burst(1'b0, 1'b1, "R3");

        // R2: reset pulse keeps the flag
        rst_n = 1'b0;
        idle(3);
        check("R2 flag during reset", protect, 1'b1);
        rst_n = 1'b1;
        idle(1);
        check("R2 flag after reset", protect, 1'b1);

        // R4: locked burst
        for (int i = 0; i < 3; i++) wr(AW'(17'h00100 + i), 8'(i), 1'b0, "R4 locked write");
        end_burst(1'b1, 1'b1, "R4");

        // R5: unlocked burst then locked again
        key3("R5 key");
        for (int i = 0; i < 4; i++) wr(AW'(17'h00200 + i), 8'(8'h40 + i), 1'b1, "R5 unlocked data");
        end_burst(1'b1, 1'b1, "R5");
        wr(17'h00300, 8'h99, 1'b0, "R5 next burst locked");
        end_burst(1'b1, 1'b1, "R5 relock");

        // R8: spacing sweep between key steps, up to the window length
        for (int g = 1; g <= WIN; g++) begin
            wr(17'h05555, 8'hAA, 1'b0, "R8 gap step1"); idle(g - 1);
            wr(17'h02AAA, 8'h55, 1'b0, "R8 gap step2"); idle(g - 1);
            wr(17'h05555, 8'hA0, 1'b0, "R8 gap step3"); idle(g - 1);
            wr(17'h00400, 8'(g), 1'b1, "R8 data within window");
            end_burst(1'b1, 1'b1, "R8 gap");
        end

        // R8/R9: one cycle too long, burst closes and the next write lands in the write period
        wr(17'h05555, 8'hAA, 1'b0, "R8 late step1");
        idle(WIN);
        check("R8 window expired", busy, 1'b1);
        wr(17'h02AAA, 8'h55, 1'b0, "R9 write while busy ignored");
        while (busy) @(negedge clk);
        wr(17'h05555, 8'hA0, 1'b0, "R8 progress discarded");
        wr(17'h00500, 8'h11, 1'b0, "R8 still locked");
        end_burst(1'b1, 1'b1, "R8 late");

        // R7: break the six-write key at every step while protected
        for (int p = 1; p <= 5; p++) begin
            for (int s = 0; s < p; s++) wr(step_addr(s), step_data(s), 1'b0, "R7 prefix");
            wr(17'h00123, 8'h11, 1'b0, "R7 breaking write protected");
            wr(17'h00124, 8'h12, 1'b0, "R7 after break locked");
            end_burst(1'b1, 1'b1, "R7 flag kept");
        end

        // R6: six-write key, then data, flag falls at end of write period
        for (int s = 0; s < 6; s++) wr(step_addr(s), step_data(s), 1'b0, "R6 key step");
        wr(17'h00600, 8'h5A, 1'b1, "R6 data after key");
        wr(17'h00601, 8'hA5, 1'b1, "R6 data after key 2");
        end_burst(1'b1, 1'b0, "R6");

        // R7: broken key while unprotected is ordinary data
        wr(17'h05555, 8'hAA, 1'b0, "R7 step1 consumed");
        wr(17'h00040, 8'h77, 1'b1, "R7 breaking write loaded");
        wr(17'h02AAA, 8'h55, 1'b1, "R7 stale step2 ordinary");
        wr(17'h05555, 8'hA0, 1'b1, "R7 stale step3 ordinary");
        end_burst(1'b0, 1'b0, "R7 no arm");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule